// File: doc/BRIEF.md
# Partial-Length Load/Store Alignment Unit

This unit reads or writes a run of 0 to 15 bytes that may start at any byte address. The memory behind it accepts only aligned 16-byte words. For each request the unit takes the start address and a length operand. It works out whether the run lies inside one aligned word or crosses into the next one, and it issues one or two word requests, lower word first.

On a load, the unit collects the returned words, joins them and shifts them right by the start offset, so the first requested byte lands in byte lane 0 of a 128-bit result. Every lane at or above the length reads as zero. On a store, the unit shifts the store data to the start offset and splits it into one or two word writes. Each write carries a 16-bit byte-enable mask that covers only the requested bytes.

A zero length touches no memory at all. The unit reports this with a flag on its response, so whatever sits around it can skip translation and fault handling for that request. Only one request is in flight at a time.

Top module: `pls_align_unit`

## Requirements
- R1: Only the low 4 bits of `req_len` set the byte count (0 to 15). The bits above them have no effect on any output.
- R2: A request with a byte count of zero issues no memory request. `rsp_valid` is high in the cycle after the request is accepted, with `rsp_accessed` = 0, and a load returns all-zero data.
- R3: Let off = address mod 16. When off + count <= 16, exactly one word request is issued (`mem_req_idx` = 0). When off + count > 16, two are issued (idx 0, then idx 1). `mem_req_addr` carries the byte address of the word, with its low 4 bits zero: the start address rounded down for idx 0, and that address plus 16 for idx 1.
- R4: For a load, result byte lane i (bits 8i+7..8i) equals the memory byte at start address + i for every i < count. Every lane i >= count is zero.
- R5: Word responses may arrive in either order. `mem_rsp_idx` = 0 names the lower word and 1 names the upper word, and the result does not depend on the order of arrival.
- R6: In a store word request with index k, enable bit b is set exactly when the byte at word address + b lies in [start, start + count). Store data byte j (bits 8j+7..8j of `req_wdata`) appears in the lane of the word that holds byte start + j.
- R7: A load's `rsp_valid` is a one-cycle pulse in the cycle after the clock edge that captures its last missing word response. A store's `rsp_valid` is a one-cycle pulse in the cycle after its last word write is accepted.
- R8: `req_ready` is high only while no request is in progress. While a request is in progress, no other request is accepted.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the word request's address, index, enables and data stay unchanged.
- R10: A request with a non-zero byte count responds with `rsp_accessed` = 1, and its first word request appears in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted on this edge if valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_OP_W | Length operand, low 4 bits used |
| req_wdata | input | 128 | Store bytes, byte 0 in bits 7..0 |
| mem_req_valid | output | 1 | Word request present |
| mem_req_ready | input | 1 | Memory takes the word request |
| mem_req_write | output | 1 | Word request is a write |
| mem_req_idx | output | 1 | 0 = lower word, 1 = upper word |
| mem_req_addr | output | ADDR_W | Aligned word byte address |
| mem_req_be | output | 16 | Per-byte enables of the word |
| mem_req_wdata | output | 128 | Write data of the word |
| mem_rsp_valid | input | 1 | Read word returned |
| mem_rsp_idx | input | 1 | Index of the returned word |
| mem_rsp_rdata | input | 128 | Returned word data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_store | output | 1 | Completion belongs to a store |
| rsp_accessed | output | 1 | 1 if memory was touched (count non-zero) |
| rsp_rdata | output | 128 | Aligned, zero-filled load result |

## Verification
The first word request is due in the cycle after acceptance. The second is due in the cycle after the first is taken. A zero-count response is due in the cycle after acceptance. A load result is due in the cycle after the edge that captures its last missing response, and a store completion in the cycle after its last write is taken. The bench drives every input on a falling edge and samples on the next falling edge after the edge that should produce the result. At the intermediate falling edges it also checks that no early or extra pulse or request shows up: between two out-of-order responses, while a write request is stalled, and after the last word.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int WORD_BYTES = 16;
    localparam int DATA_W     = WORD_BYTES * 8;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int PAIR_BYTES = 2 * WORD_BYTES;
    localparam int PAIR_W     = 2 * DATA_W;

    typedef logic [DATA_W-1:0]     word_t;
    typedef logic [WORD_BYTES-1:0] bmask_t;
    typedef logic [OFF_W-1:0]      off_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } fsm_t;

    typedef struct packed {
        logic is_store;
        logic active;
        logic span;
        off_t off;
        off_t cnt;
    } xfer_t;

    // Bytes [off, off+cnt) of a two-word window set to one
    function automatic logic [PAIR_BYTES-1:0] window_mask(input off_t off, input off_t cnt);
        logic [PAIR_BYTES-1:0] run;
        run = ({{(PAIR_BYTES-1){1'b0}}, 1'b1} << cnt) - 1'b1;
        return run << off;
    endfunction
endpackage

// File: rtl/pls_span_calc.sv
module pls_span_calc
    import pls_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_OP_W = 8
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LEN_OP_W-1:0]     len_op,
    output off_t                    off,
    output off_t                    cnt,
    output logic                    span,
    output logic                    active,
    output logic [ADDR_W-OFF_W-1:0] base_word
);
    logic [OFF_W:0] reach;

    assign off       = addr[OFF_W-1:0];
    assign cnt       = len_op[OFF_W-1:0];
    assign base_word = addr[ADDR_W-1:OFF_W];
    assign active    = (cnt != '0);
    assign reach     = {1'b0, off} + {1'b0, cnt};
    assign span      = (reach > (OFF_W+1)'(WORD_BYTES));

    generate
        if (LEN_OP_W > OFF_W) begin : g_hi
            logic unused_len_hi;
            assign unused_len_hi = ^len_op[LEN_OP_W-1:OFF_W];
        end
    endgenerate
endmodule

// File: rtl/pls_load_align.sv
module pls_load_align
    import pls_pkg::*;
(
    input  word_t word_lo,
    input  word_t word_hi,
    input  off_t  off,
    input  off_t  cnt,
    output word_t result
);
    logic [PAIR_W-1:0] joined;
    logic [PAIR_W-1:0] shifted;

    assign joined  = {word_hi, word_lo};
    assign shifted = joined >> {off, 3'b000};

    genvar g;
    generate
        for (g = 0; g < WORD_BYTES; g++) begin : g_lane
            assign result[g*8 +: 8] = (OFF_W'(g) < cnt) ? shifted[g*8 +: 8] : 8'h00;
        end
    endgenerate

    logic unused_upper;
    assign unused_upper = ^shifted[PAIR_W-1:DATA_W];
endmodule

// File: rtl/pls_store_split.sv
module pls_store_split
    import pls_pkg::*;
(
    input  word_t  wdata,
    input  off_t   off,
    input  off_t   cnt,
    output word_t  data_lo,
    output word_t  data_hi,
    output bmask_t be_lo,
    output bmask_t be_hi
);
    logic [PAIR_W-1:0]     placed;
    logic [PAIR_BYTES-1:0] mask;

    assign placed  = {{DATA_W{1'b0}}, wdata} << {off, 3'b000};
    assign mask    = window_mask(off, cnt);
    assign data_lo = placed[DATA_W-1:0];
    assign data_hi = placed[PAIR_W-1:DATA_W];
    assign be_lo   = mask[WORD_BYTES-1:0];
    assign be_hi   = mask[PAIR_BYTES-1:WORD_BYTES];
endmodule

// File: rtl/pls_align_unit.sv
module pls_align_unit
    import pls_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_OP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_store,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_OP_W-1:0]   req_len,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_write,
    output logic                  mem_req_idx,
    output logic [ADDR_W-1:0]     mem_req_addr,
    output logic [WORD_BYTES-1:0] mem_req_be,
    output logic [DATA_W-1:0]     mem_req_wdata,
    input  logic                  mem_rsp_valid,
    input  logic                  mem_rsp_idx,
    input  logic [DATA_W-1:0]     mem_rsp_rdata,
    output logic                  rsp_valid,
    output logic                  rsp_store,
    output logic                  rsp_accessed,
    output logic [DATA_W-1:0]     rsp_rdata
);
    localparam int BW = ADDR_W - OFF_W;

    fsm_t          state;
    xfer_t         xf;
    logic [BW-1:0] base_q;
    word_t         wdata_q;
    word_t         rword_q [2];
    logic          issue_idx;
    logic [1:0]    got_q;

    off_t          in_off, in_cnt;
    logic          in_span, in_active;
    logic [BW-1:0] in_base;

    pls_span_calc #(.ADDR_W(ADDR_W), .LEN_OP_W(LEN_OP_W)) u_span (
        .addr      (req_addr),
        .len_op    (req_len),
        .off       (in_off),
        .cnt       (in_cnt),
        .span      (in_span),
        .active    (in_active),
        .base_word (in_base)
    );

    word_t  ld_result;
    word_t  st_lo, st_hi;
    bmask_t be_lo, be_hi;

    pls_load_align u_load (
        .word_lo (rword_q[0]),
        .word_hi (rword_q[1]),
        .off     (xf.off),
        .cnt     (xf.cnt),
        .result  (ld_result)
    );

    pls_store_split u_store (
        .wdata   (wdata_q),
        .off     (xf.off),
        .cnt     (xf.cnt),
        .data_lo (st_lo),
        .data_hi (st_hi),
        .be_lo   (be_lo),
        .be_hi   (be_hi)
    );

    logic       req_fire, word_fire, last_issue, rsp_take, all_got;
    logic [1:0] need, got_nxt;

    assign req_fire   = req_valid && req_ready;
    assign word_fire  = mem_req_valid && mem_req_ready;
    assign last_issue = (issue_idx == xf.span);
    assign need       = {xf.span, 1'b1};
    assign rsp_take   = mem_rsp_valid && !xf.is_store
                        && (state == ST_ISSUE || state == ST_WAIT);
    assign got_nxt    = got_q | (rsp_take ? (2'b01 << mem_rsp_idx) : 2'b00);
    assign all_got    = ((got_nxt & need) == need);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            xf         <= '0;
            base_q     <= '0;
            wdata_q    <= '0;
            rword_q[0] <= '0;
            rword_q[1] <= '0;
            issue_idx  <= 1'b0;
            got_q      <= 2'b00;
        end else begin
            if (rsp_take) begin
                rword_q[mem_rsp_idx] <= mem_rsp_rdata;
            end
            case (state)
                ST_IDLE: begin
                    if (req_fire) begin
                        xf.is_store <= req_store;
                        xf.active   <= in_active;
                        xf.span     <= in_span;
                        xf.off      <= in_off;
                        xf.cnt      <= in_cnt;
                        base_q      <= in_base;
                        wdata_q     <= req_wdata;
                        issue_idx   <= 1'b0;
                        got_q       <= 2'b00;
                        state       <= in_active ? ST_ISSUE : ST_DONE;
                    end
                end
                ST_ISSUE: begin
                    got_q <= got_nxt;
                    if (word_fire) begin
                        if (last_issue) begin
                            if (xf.is_store || all_got) state <= ST_DONE;
                            else                        state <= ST_WAIT;
                        end else begin
                            issue_idx <= 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    got_q <= got_nxt;
                    if (all_got) state <= ST_DONE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_ISSUE);
    assign mem_req_write = xf.is_store;
    assign mem_req_idx   = issue_idx;
    assign mem_req_addr  = {base_q + BW'(issue_idx), {OFF_W{1'b0}}};
    assign mem_req_be    = issue_idx ? be_hi : be_lo;
    assign mem_req_wdata = issue_idx ? st_hi : st_lo;

    assign rsp_valid     = (state == ST_DONE);
    assign rsp_store     = xf.is_store;
    assign rsp_accessed  = xf.active;
    assign rsp_rdata     = xf.is_store ? '0 : ld_result;
endmodule

// File: rtl/pls_align_chk.sv
module pls_align_chk
    import pls_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_OP_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [LEN_OP_W-1:0]   req_len,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic                  mem_req_idx,
    input logic [ADDR_W-1:0]     mem_req_addr,
    input logic [WORD_BYTES-1:0] mem_req_be,
    input logic                  rsp_valid,
    input logic                  rsp_store,
    input logic                  rsp_accessed,
    input logic [DATA_W-1:0]     rsp_rdata
);
    off_t  cap_cnt;
    word_t above_mask;

    always_ff @(posedge clk) begin
        if (rst) cap_cnt <= '0;
        else if (req_valid && req_ready) cap_cnt <= req_len[OFF_W-1:0];
    end

    always_comb begin
        for (int b = 0; b < WORD_BYTES; b++) begin
            above_mask[b*8 +: 8] = (b >= int'(cap_cnt)) ? 8'hFF : 8'h00;
        end
    end

    // R2
    zero_len_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_len[OFF_W-1:0] == '0)
        |=> (rsp_valid && !rsp_accessed && !mem_req_valid));

    // R10
    active_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_len[OFF_W-1:0] != '0)
        |=> (mem_req_valid && !mem_req_idx));

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready)
        |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_idx)
             && $stable(mem_req_be)));

    // R6
    be_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_be != '0));

    // R8
    single_flight_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || mem_req_valid) |-> !req_ready);

    // R7
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_store) |-> ((rsp_rdata & above_mask) == '0));
endmodule

bind pls_align_unit pls_align_chk #(.ADDR_W(ADDR_W), .LEN_OP_W(LEN_OP_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_len       (req_len),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_idx   (mem_req_idx),
    .mem_req_addr  (mem_req_addr),
    .mem_req_be    (mem_req_be),
    .rsp_valid     (rsp_valid),
    .rsp_store     (rsp_store),
    .rsp_accessed  (rsp_accessed),
    .rsp_rdata     (rsp_rdata)
);

// File: tb/tb_pls_align_unit.sv
module tb_pls_align_unit;
    import pls_pkg::*;

    localparam int AW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_ready, req_store;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;
    logic [127:0]  req_wdata;
    logic          mem_req_valid, mem_req_ready, mem_req_write, mem_req_idx;
    logic [AW-1:0] mem_req_addr;
    logic [15:0]   mem_req_be;
    logic [127:0]  mem_req_wdata;
    logic          mem_rsp_valid, mem_rsp_idx;
    logic [127:0]  mem_rsp_rdata;
    logic          rsp_valid, rsp_store, rsp_accessed;
    logic [127:0]  rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pls_align_unit #(.ADDR_W(AW), .LEN_OP_W(LW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_idx(mem_req_idx),
        .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_idx(mem_rsp_idx),
        .mem_rsp_rdata(mem_rsp_rdata),
        .rsp_valid(rsp_valid), .rsp_store(rsp_store),
        .rsp_accessed(rsp_accessed), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] memb(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'd37 + 32'd11;
        return t[7:0];
    endfunction

    function automatic logic [127:0] mem_word(input logic [31:0] wa);
        logic [127:0] w;
        for (int b = 0; b < 16; b++) w[b*8 +: 8] = memb(wa + 32'(b));
        return w;
    endfunction

    function automatic logic [127:0] store_pattern();
        logic [127:0] w;
        for (int j = 0; j < 16; j++) w[j*8 +: 8] = 8'hA0 + 8'(j);
        return w;
    endfunction

    task automatic send(input bit st, input logic [31:0] addr, input logic [7:0] lenop);
        @(negedge clk);
        check("R8 ready while idle", 128'(req_ready), 128'd1);
        req_valid = 1'b1; req_store = st; req_addr = addr; req_len = lenop;
        req_wdata = store_pattern();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Load scenario: swap returns upper word first, stall holds ready low 2 cycles
    task automatic run_load(input logic [31:0] addr, input logic [7:0] lenop,
                            input bit swap, input bit stall, input string tag);
        int cnt, off, nexp, n, cyc;
        logic [31:0] base;
        logic [127:0] exp;
        cnt = int'(lenop[3:0]);
        off = int'(addr[3:0]);
        base = addr & 32'hFFFF_FFF0;
        nexp = (cnt == 0) ? 0 : ((off + cnt > 16) ? 2 : 1);
        exp = '0;
        for (int i = 0; i < cnt; i++) exp[i*8 +: 8] = memb(addr + 32'(i));
        send(1'b0, addr, lenop);
        if (nexp == 0) begin
            check({tag, " R2 no word request"}, 128'(mem_req_valid), 128'd0);
            check({tag, " R2 response pulse"}, 128'(rsp_valid), 128'd1);
            check({tag, " R2 accessed flag"}, 128'(rsp_accessed), 128'd0);
            check({tag, " R2 zero data"}, rsp_rdata, 128'd0);
            @(negedge clk);
            return;
        end
        check({tag, " R10 first word request"}, 128'(mem_req_valid), 128'd1);
        n = 0; cyc = 0;
        while (n < nexp && cyc < 30) begin
            mem_req_ready = !(stall && cyc < 2);
            if (mem_req_valid && mem_req_ready) begin
                check({tag, " R3 word index"}, 128'(mem_req_idx), 128'(n));
                check({tag, " R3 word address"}, 128'(mem_req_addr), 128'(base + 32'(16 * n)));
                n++;
            end
            @(negedge clk);
            cyc++;
        end
        mem_req_ready = 1'b1;
        check({tag, " R3 word count"}, 128'(n), 128'(nexp));
        check({tag, " R3 no extra word"}, 128'(mem_req_valid), 128'd0);
        check({tag, " R7 no early result"}, 128'(rsp_valid), 128'd0);
        for (int k = 0; k < nexp; k++) begin
            int w;
            w = (swap && nexp == 2) ? (1 - k) : k;
            mem_rsp_valid = 1'b1;
            mem_rsp_idx = w[0];
            mem_rsp_rdata = mem_word(base + 32'(16 * w));
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (k < nexp - 1) check({tag, " R7 waits for both words"}, 128'(rsp_valid), 128'd0);
        end
        check({tag, " R7 result pulse"}, 128'(rsp_valid), 128'd1);
        check({tag, " R4 R5 load data"}, rsp_rdata, exp);
        check({tag, " R10 accessed flag"}, 128'(rsp_accessed), 128'd1);
        @(negedge clk);
        check({tag, " R7 single pulse"}, 128'(rsp_valid), 128'd0);
    endtask

    task automatic run_store(input logic [31:0] addr, input logic [7:0] lenop,
                             input bit stall, input string tag);
        int cnt, off, nexp, n, cyc;
        logic [31:0] base, held;
        logic [127:0] pat;
        bit seen_stall;
        cnt = int'(lenop[3:0]);
        off = int'(addr[3:0]);
        base = addr & 32'hFFFF_FFF0;
        nexp = (cnt == 0) ? 0 : ((off + cnt > 16) ? 2 : 1);
        pat = store_pattern();
        held = '0;
        seen_stall = 1'b0;
        send(1'b1, addr, lenop);
        if (nexp == 0) begin
            check({tag, " R2 no write"}, 128'(mem_req_valid), 128'd0);
            check({tag, " R2 done pulse"}, 128'(rsp_valid), 128'd1);
            check({tag, " R2 accessed flag"}, 128'(rsp_accessed), 128'd0);
            @(negedge clk);
            return;
        end
        n = 0; cyc = 0;
        while (n < nexp && cyc < 30) begin
            mem_req_ready = !(stall && cyc < 2);
            check({tag, " R7 no early done"}, 128'(rsp_valid), 128'd0);
            if (mem_req_valid && !mem_req_ready) begin
                if (seen_stall) check({tag, " R9 held address"}, 128'(mem_req_addr), 128'(held));
                held = mem_req_addr;
                seen_stall = 1'b1;
            end
            if (mem_req_valid && mem_req_ready) begin
                logic [15:0]  ebe;
                logic [127:0] bmask, edata;
                ebe = '0; bmask = '0; edata = '0;
                for (int b = 0; b < 16; b++) begin
                    int pos;
                    pos = 16 * n + b;
                    if (pos >= off && pos < off + cnt) begin
                        ebe[b] = 1'b1;
                        bmask[b*8 +: 8] = 8'hFF;
                        edata[b*8 +: 8] = pat[(pos - off)*8 +: 8];
                    end
                end
                check({tag, " R6 write flag"}, 128'(mem_req_write), 128'd1);
                check({tag, " R3 word index"}, 128'(mem_req_idx), 128'(n));
                check({tag, " R3 word address"}, 128'(mem_req_addr), 128'(base + 32'(16 * n)));
                check({tag, " R6 byte enables"}, 128'(mem_req_be), 128'(ebe));
                check({tag, " R6 placed data"}, mem_req_wdata & bmask, edata);
                n++;
            end
            @(negedge clk);
            cyc++;
        end
        mem_req_ready = 1'b1;
        check({tag, " R3 word count"}, 128'(n), 128'(nexp));
        check({tag, " R7 done pulse"}, 128'(rsp_valid), 128'd1);
        check({tag, " R7 store flag"}, 128'(rsp_store), 128'd1);
        check({tag, " R10 accessed flag"}, 128'(rsp_accessed), 128'd1);
        @(negedge clk);
        check({tag, " R8 idle again"}, 128'(req_ready), 128'd1);
    endtask

    task automatic reset_test();
        @(negedge clk);
        check("reset req_ready", 128'(req_ready), 128'd1);
        check("reset mem_req_valid", 128'(mem_req_valid), 128'd0);
        check("reset rsp_valid", 128'(rsp_valid), 128'd0);
    endtask

    task automatic busy_reject_test();
        // R8: a second request during a load is not taken
        send(1'b0, 32'h0000_0104, 8'h04);
        req_valid = 1'b1; req_addr = 32'h0000_0200; req_len = 8'h00;
        check("R8 ready low while busy", 128'(req_ready), 128'd0);
        @(negedge clk);
        check("R8 ready low while busy", 128'(req_ready), 128'd0);
        req_valid = 1'b0;
        check("R8 word of first request", 128'(mem_req_addr), 128'h100);
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_idx = 1'b0; mem_rsp_rdata = mem_word(32'h100);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R8 result of first request", 128'(rsp_accessed), 128'd1);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_store = 1'b0; req_addr = '0; req_len = '0; req_wdata = '0;
        mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_idx = 1'b0; mem_rsp_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        reset_test();
        run_load(32'h0000_1003, 8'h05, 1'b0, 1'b0, "R4 single word load");
        run_load(32'h0000_1001, 8'h0F, 1'b0, 1'b0, "R3 exact fit load");
        run_load(32'h0000_100F, 8'h02, 1'b0, 1'b0, "R3 span load in order");
        run_load(32'h0000_200A, 8'h0C, 1'b1, 1'b0, "R5 span load swapped");
        run_load(32'h0000_3007, 8'hF9, 1'b1, 1'b1, "R1 upper length bits");
        run_load(32'h0000_4009, 8'h00, 1'b0, 1'b0, "R2 zero load");
        run_load(32'h0000_400E, 8'h30, 1'b0, 1'b0, "R1 R2 zero low bits");
        run_store(32'h0000_5004, 8'h07, 1'b0, "R6 single word store");
        run_store(32'h0000_600B, 8'h0E, 1'b1, "R9 span store stalled");
        run_store(32'h0000_7000, 8'h0F, 1'b0, "R6 aligned store");
        run_store(32'h0000_800D, 8'h20, 1'b0, "R2 zero store");
        busy_reject_test();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule